// File: doc/BRIEF.md
# Chip-Select Serial Angle Readout

This block lets an external host read a 12-bit absolute shaft angle over three wires. The host pulls an active-low select line, then toggles a serial clock. The block takes a snapshot of the live angle when select goes low. It then presents the angle one bit at a time, most significant bit first, and moves to the next bit on every falling edge of the serial clock. When select is high the block does not drive the data line. Several converters can therefore share one data wire, each with its own select.

Select and serial clock are asynchronous to the block. Both pass through two-flop synchronisers into the system clock domain, and edges are found there. The system clock must run several times faster than the serial clock, whose top rate is 2 MHz. The data value and its output enable are separate outputs. A pad cell or a bus multiplexer at chip level turns them into a tri-state line.

Top module: `angle_serial_port`

## Requirements
- R1: While reset is asserted and after reset is released, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: While select has been high for at least one synchronised cycle, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R3: A falling edge on `sel_n_i` sets `sdo_oe_o` to 1 and puts bit 11 of the angle on `sdo_o`. Both are visible no later than three system clocks after the edge.
- R4: The angle is captured once, on the select falling edge. Later changes of `angle_i` do not change the frame in progress.
- R5: While selected, the k-th falling edge of `sck_i` (k = 1..11) puts bit 11-k of the captured angle on `sdo_o`. The order is MSB first and LSB last.
- R6: On the 12th falling edge of `sck_i` and on every falling edge after it, `sdo_o` holds 0 while `sdo_oe_o` stays 1.
- R7: Raising select in the middle of a frame ends the frame: `sdo_oe_o` and `sdo_o` fall to 0. The next select recaptures the current angle and starts again from bit 11.
- R8: Serial clock edges while deselected have no effect. The next frame still starts with bit 11.
- R9: Rising edges of `sck_i` do not change `sdo_o`.
- R10: If the select fall and a serial clock fall reach the core in the same cycle, the capture wins and no shift happens. `sdo_o` shows bit 11.
- R11: If the select rise and a serial clock fall reach the core in the same cycle, the abort wins and `sdo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronously upstream |
| angle_i | input | 12 | Live absolute angle in pure binary |
| sel_n_i | input | 1 | Active-low select from the host, asynchronous |
| sck_i | input | 1 | Serial clock from the host, asynchronous; bits advance on its falling edge |
| sdo_o | output | 1 | Serial data value, 0 when not driving |
| sdo_oe_o | output | 1 | Output enable for the shared data line |

## Verification
Two events can reach the core in the same system cycle. One is a select edge, which starts or ends a frame. The other is a serial clock falling edge, which shifts the frame. The bench makes them coincide by changing `sel_n_i` and `sck_i` on the same clock edge, so both pass through their synchronisers together. For a select fall it checks that `sdo_o` shows bit 11 of the new angle and that the next falling edge shows bit 10. For a select rise it checks that the enable drops at once and that the next frame starts from bit 11 again.

// File: rtl/sps_pkg.sv
package sps_pkg;
  // Bit positions of the asynchronous control lines inside the synchroniser bundle.
  localparam int unsigned SEL_IDX = 0;
  localparam int unsigned SCK_IDX = 1;
  localparam int unsigned LINES   = 2;

  // Idle levels: select released (high), serial clock low so reset creates no falling edge.
  localparam logic [LINES-1:0] LINE_IDLE = 2'b01;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int unsigned     W       = 2,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sps_edge.sv
module sps_edge #(
  parameter int unsigned  W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
  assign rise_o = ~prev_q & lvl_i;
endmodule

// File: rtl/sps_shifter.sv
module sps_shifter #(
  parameter int unsigned ANGLE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               sel_lvl_i,
  input  logic               sel_fall_i,
  input  logic               sel_rise_i,
  input  logic               sck_fall_i,
  input  logic               sck_rise_i,
  output logic               bit_o,
  output logic               drive_o
);
  localparam int unsigned        CNT_W    = $clog2(ANGLE_W + 1);
  localparam logic [CNT_W-1:0]   CNT_FULL = CNT_W'(ANGLE_W);

  logic [ANGLE_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               act_q, act_d;
  logic               upd_en;

  // Clock enable: only frame start, frame end, or an in-frame shift touch state.
  assign upd_en = sel_fall_i | sel_rise_i | (act_q & sck_fall_i);

  // Next state. Select edges take priority over a simultaneous shift.
  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    if (sel_fall_i) begin
      shreg_d = angle_i;
      cnt_d   = '0;
      act_d   = 1'b1;
    end else if (sel_rise_i) begin
      shreg_d = '0;
      cnt_d   = '0;
      act_d   = 1'b0;
    end else if (act_q && sck_fall_i) begin
      shreg_d = {shreg_q[ANGLE_W-2:0], 1'b0};
      cnt_d   = (cnt_q == CNT_FULL) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else if (upd_en) begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
    end
  end

  assign bit_o   = act_q & shreg_q[ANGLE_W-1];
  assign drive_o = act_q;

  // R2: select held high for two synchronised cycles means the line is released.
  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lvl_i && $past(sel_lvl_i)) |-> !drive_o);

  // R3, R4: a select fall loads the angle seen in that cycle and starts driving.
  a_r3_capture_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall_i |=> (drive_o && shreg_q == $past(angle_i)));

  // R5: an in-frame serial fall moves the frame one position toward the MSB.
  a_r5_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && sck_fall_i && !sel_fall_i && !sel_rise_i)
      |=> (shreg_q[ANGLE_W-1:1] == $past(shreg_q[ANGLE_W-2:0]) && !shreg_q[0]));

  // R6: once all bits are out the line stays low.
  a_r6_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q == CNT_FULL) |-> !bit_o);

  // R7, R11: a select rise always ends the frame, even with a serial fall.
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise_i |=> !drive_o);

  // R9: a rising serial edge on its own leaves the frame untouched.
  a_r9_rise_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise_i && !sel_fall_i && !sel_rise_i) |=> $stable(shreg_q));

  // R10: capture beats a coincident shift; counter starts from zero.
  a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fall_i && sck_fall_i) |=> (cnt_q == '0 && bit_o == $past(angle_i[ANGLE_W-1])));
endmodule

// File: rtl/angle_serial_port.sv
module angle_serial_port
  import sps_pkg::*;
#(
  parameter int unsigned ANGLE_W     = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               sel_n_i,
  input  logic               sck_i,
  output logic               sdo_o,
  output logic               sdo_oe_o
);
  logic [LINES-1:0] line_async, line_sync, line_fall, line_rise;

  assign line_async[SEL_IDX] = sel_n_i;
  assign line_async[SCK_IDX] = sck_i;

  sps_sync #(
    .W       (LINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (LINE_IDLE)
  ) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (line_async),
    .sync_o  (line_sync)
  );

  sps_edge #(
    .W       (LINES),
    .RST_VAL (LINE_IDLE)
  ) i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (line_sync),
    .fall_o (line_fall),
    .rise_o (line_rise)
  );

  sps_shifter #(
    .ANGLE_W (ANGLE_W)
  ) i_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .angle_i    (angle_i),
    .sel_lvl_i  (line_sync[SEL_IDX]),
    .sel_fall_i (line_fall[SEL_IDX]),
    .sel_rise_i (line_rise[SEL_IDX]),
    .sck_fall_i (line_fall[SCK_IDX]),
    .sck_rise_i (line_rise[SCK_IDX]),
    .bit_o      (sdo_o),
    .drive_o    (sdo_oe_o)
  );
endmodule

// File: tb/test_angle_serial_port.sv
module test_angle_serial_port;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] angle = '0;
  logic         sel_n = 1'b1;
  logic         sck = 1'b0;
  logic         sdo, sdo_oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  angle_serial_port #(.ANGLE_W(W), .SYNC_STAGES(2)) i_angle_serial_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .angle_i  (angle),
    .sel_n_i  (sel_n),
    .sck_i    (sck),
    .sdo_o    (sdo),
    .sdo_oe_o (sdo_oe)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck = 1'b1; settle();
    sck = 1'b0; settle();
  endtask

  task automatic run_frame(input logic [W-1:0] a);
    angle = a;
    sel_n = 1'b0; settle();
    check("R3 enable after select", sdo_oe, 1'b1);
    check("R3 msb after select", sdo, a[W-1]);
    angle = ~a;                                   // R4: live angle moves on
    for (int i = 1; i < W; i++) begin
      sck = 1'b1; settle();
      check("R9 rising edge inert", sdo, a[W-i]);
      sck = 1'b0; settle();
      check("R5 bit order", sdo, a[W-1-i]);
      check("R4 frame coherent", sdo_oe, 1'b1);
    end
    sck_pulse();
    check("R6 twelfth edge low", sdo, 1'b0);
    sck_pulse();
    check("R6 extra edge low", sdo, 1'b0);
    check("R6 still driving", sdo_oe, 1'b1);
    sel_n = 1'b1; settle();
    check("R2 released enable", sdo_oe, 1'b0);
    check("R2 released data", sdo, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired: got running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 enable in reset", sdo_oe, 1'b0);
    check("R1 data in reset", sdo, 1'b0);
    rst_n = 1'b1; settle();
    check("R1 enable after reset", sdo_oe, 1'b0);
    check("R1 data after reset", sdo, 1'b0);

    // R8: serial clocks while deselected, then a frame must start at the MSB.
    angle = 12'hFFF;
    repeat (3) begin
      sck_pulse();
      check("R8 idle clocks no drive", sdo_oe, 1'b0);
    end
    run_frame(12'hFFF);

    // Corner patterns and a strided sweep of the angle space (R3 R4 R5 R6).
    run_frame(12'h000);
    run_frame(12'hAAA);
    run_frame(12'h555);
    run_frame(12'h801);
    for (int a = 0; a < 4096; a += 37) run_frame(W'(a));

    // R7: abort mid-frame, new angle recaptured from bit 11.
    angle = 12'h3C5;
    sel_n = 1'b0; settle();
    repeat (5) sck_pulse();
    check("R7 mid-frame bit", sdo, 1'b1);          // 12'h3C5 bit 6 = 1
    sel_n = 1'b1; settle();
    check("R7 abort enable", sdo_oe, 1'b0);
    check("R7 abort data", sdo, 1'b0);
    run_frame(12'hC3A);

    // R10: select fall and serial fall cross the synchronisers together.
    angle = 12'h9F0;
    sck = 1'b1; settle();
    sel_n = 1'b0; sck = 1'b0; settle();
    check("R10 enable", sdo_oe, 1'b1);
    check("R10 msb kept", sdo, 1'b1);
    sck_pulse();
    check("R10 next bit 10", sdo, 1'b0);
    sck_pulse();
    check("R10 next bit 9", sdo, 1'b0);
    sck_pulse();
    check("R10 next bit 8", sdo, 1'b1);

    // R11: select rise and serial fall together, abort wins.
    sck = 1'b1; settle();
    sel_n = 1'b1; sck = 1'b0; settle();
    check("R11 enable dropped", sdo_oe, 1'b0);
    check("R11 data low", sdo, 1'b0);
    run_frame(12'h6B7);

    finish_run();
  end
endmodule